// File: doc/BRIEF.md
# ATA PIO Command-Word Bus Sequencer

This block turns a stream of 16-bit command words into timed programmed-I/O cycles on a parallel ATA bus. Each accepted word is one of four things. It can be a task-file register read, a task-file register write, a repeated data-port transfer, or a device-select word. A device-select word picks the master or slave device and sets whether data counts are in bytes or in 8-byte blocks. Data-port transfers take their words from a write-data port and hand words read from the bus to a read-data port. Both ports are plain valid/ready ports whose storage sits outside the block.

Every bus cycle passes through four phases: address setup, strobe, data hold and recovery. Each phase length is a clock count taken from one of four timing words: a register-access set and a data-port set for each of the two devices. Each timing word packs recovery in [31:24], hold in [23:16], strobe width in [15:8] and setup in [7:0]. A per-device ready-wait enable lets the device stretch the strobe through IORDY. An abort input ends the running command and raises a sticky error. A soft reset input returns the block to idle and drains the command source.

Top module: `ata_pio_seq`

## Requirements
- R1: A word with bits[15:13]=3'b001 runs one register read cycle with ata_cs=bits[12:11] and ata_da=bits[10:8]. It pushes {8'h00, low byte of ata_din} to the read port, sampled in the last strobe cycle. Bits[7:0] of the word are ignored.
- R2: A word with bits[15:13]=3'b101 runs one register write cycle with ata_cs=bits[12:11] and ata_da=bits[10:8]. It drives {8'h00, bits[7:0]} on ata_dout with ata_doe high during strobe and hold.
- R3: A word with bits[14:13]=2'b10 is a data transfer, a write when bit 15 is 1 and a read when it is 0. With N=bits[12:0], it runs N+1 data cycles in byte unit or 4*(N+1) cycles in block unit, each with ata_cs=2'b10 and ata_da=3'b000. Full 16-bit words move between the bus and the data ports.
- R4: A word whose bits[15:2] equal 14'h2740 makes no bus activity. It sets dev_sel from bit 0 (1 = slave) and blk_unit from bit 1 (1 = 8-byte blocks).
- R5: A cycle lasts max(T1,1)+max(T2,1)+max(T4,1)+max(TEOC,1) clocks. The fields are T1 [7:0], T2 [15:8], T4 [23:16] and TEOC [31:24]. Register commands use the register timing word of the selected device and data transfers use its data timing word. At most one strobe is low at a time.
- R6: When iordy_en[dev_sel] is 1, the strobe stays low past T2 while ata_iordy is low. When it is 0, ata_iordy is ignored.
- R7: A write data cycle holds in setup until wr_valid is high, and pops the word (wr_ready) in the cycle before the strobe. A read cycle holds in setup until rd_ready is high. No phase is shortened by a stall.
- R8: busy is high from the cycle after acceptance until the last recovery ends. rem_cnt shows the number of cycles not yet completed and never rises while busy.
- R9: abort while busy returns the block to idle on the next edge, releases the strobes and sets the sticky term_err. A pending write-port pop in that cycle is suppressed. abort while idle has no effect.
- R10: While soft_rst is high, the block is idle and cmd_ready is 1, and incoming words are discarded. term_err, illegal_err, dev_sel and blk_unit are cleared.
- R11: Any other word is dropped without bus activity and sets the sticky illegal_err.
- R12: After reset: busy=0, rem_cnt=0, both strobes high, cmd_ready=1, all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word available |
| cmd_word | input | 16 | Command word |
| cmd_ready | output | 1 | Command word taken this cycle |
| wr_valid | input | 1 | Write-data word available |
| wr_data | input | 16 | Write-data word |
| wr_ready | output | 1 | Write-data word popped |
| rd_valid | output | 1 | Read word pushed |
| rd_data | output | 16 | Read word |
| rd_ready | input | 1 | Read port has room |
| reg_tim0 | input | 32 | Register timing, device 0 |
| dat_tim0 | input | 32 | Data timing, device 0 |
| reg_tim1 | input | 32 | Register timing, device 1 |
| dat_tim1 | input | 32 | Data timing, device 1 |
| iordy_en | input | 2 | Ready-wait enable per device |
| abort | input | 1 | Terminate current operation |
| soft_rst | input | 1 | Return to idle, drain commands |
| ata_cs | output | 2 | Chip-select field |
| ata_da | output | 3 | Device address |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Bus data out |
| ata_doe | output | 1 | Bus data output enable |
| ata_din | input | 16 | Bus data in |
| ata_iordy | input | 1 | Device ready |
| busy | output | 1 | PIO in progress |
| rem_cnt | output | 16 | Cycles not yet completed |
| term_err | output | 1 | Transfer terminated flag |
| illegal_err | output | 1 | Unrecognised command flag |
| dev_sel | output | 1 | Selected device |
| blk_unit | output | 1 | Count unit is 8-byte blocks |

## Verification
The delicate overlap is an abort that lands in the very cycle a stalled write data cycle would pop its word and start the strobe. The bench starves the write port so the block sits at the end of setup. It then raises wr_valid and abort on the same edge. The bench judges the result at the ports: the write port index must not move, no write strobe may appear, busy must fall and term_err must rise. A second overlap, soft reset arriving together with a valid command word, is judged by busy staying low and the flags reading clear.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
  } phase_e;

  typedef enum logic [2:0] {
    OP_RREG, OP_WREG, OP_DATA, OP_SETDEV, OP_BAD
  } op_e;

  localparam int unsigned TFW = 8;

  typedef struct packed {
    logic [TFW-1:0] teoc;
    logic [TFW-1:0] t4;
    logic [TFW-1:0] t2;
    logic [TFW-1:0] t1;
  } timing_t;

  localparam logic [13:0] SETDEV_TAG = 14'h2740;
endpackage

// File: rtl/ata_pio_decode.sv
module ata_pio_decode
  import ata_pio_pkg::*;
(
  input  logic [15:0] word,
  output op_e         op
);
  always_comb begin
    if (word[14:13] == 2'b10)          op = OP_DATA;
    else if (word[15:13] == 3'b001)    op = OP_RREG;
    else if (word[15:13] == 3'b101)    op = OP_WREG;
    else if (word[15:2] == SETDEV_TAG) op = OP_SETDEV;
    else                               op = OP_BAD;
  end
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q > W'(1));
    cnt_d  = load ? len : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q <= W'(1));
endmodule

// File: rtl/ata_pio_rstsync.sv
module ata_pio_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [15:0]      cmd_word,
  output logic             cmd_ready,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic             rd_ready,
  input  logic [4*TFW-1:0] reg_tim0,
  input  logic [4*TFW-1:0] dat_tim0,
  input  logic [4*TFW-1:0] reg_tim1,
  input  logic [4*TFW-1:0] dat_tim1,
  input  logic [1:0]       iordy_en,
  input  logic             abort,
  input  logic             soft_rst,
  output logic [1:0]       ata_cs,
  output logic [2:0]       ata_da,
  output logic             ata_rd_n,
  output logic             ata_wr_n,
  output logic [DW-1:0]    ata_dout,
  output logic             ata_doe,
  input  logic [DW-1:0]    ata_din,
  input  logic             ata_iordy,
  output logic             busy,
  output logic [CNT_W-1:0] rem_cnt,
  output logic             term_err,
  output logic             illegal_err,
  output logic             dev_sel,
  output logic             blk_unit
);
  localparam int unsigned WORDS_PER_BLK_LOG2 = 2;

  logic rst_i_n;
  ata_pio_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  op_e op;
  ata_pio_decode u_dec (.word(cmd_word), .op(op));

  phase_e           ph_q, ph_d;
  logic             wr_q, wr_d, dat_q, dat_d, dev_q, dev_d, blk_q, blk_d;
  logic             term_q, term_d, ill_q, ill_d, rdv_q, rdv_d;
  logic [1:0]       cs_q, cs_d;
  logic [2:0]       da_q, da_d;
  logic [DW-1:0]    dout_q, dout_d, rdd_q, rdd_d;
  logic [CNT_W-1:0] rem_q, rem_d, data_cnt;
  logic             fire, t_load, t_done, data_ok, iordy_ok, sel_data;
  logic [TFW-1:0]   t_len;
  timing_t          tim;

  assign cmd_ready = (ph_q == PH_IDLE) || soft_rst;
  assign fire      = cmd_valid && cmd_ready && !soft_rst;
  assign sel_data  = (ph_q == PH_IDLE) ? (op == OP_DATA) : dat_q;
  assign tim       = sel_data ? (dev_q ? timing_t'(dat_tim1) : timing_t'(dat_tim0))
                              : (dev_q ? timing_t'(reg_tim1) : timing_t'(reg_tim0));
  assign iordy_ok  = !iordy_en[dev_q] || ata_iordy;
  assign data_ok   = wr_q ? (!dat_q || wr_valid) : rd_ready;
  assign wr_ready  = (ph_q == PH_SETUP) && t_done && data_ok && wr_q && dat_q
                     && !abort && !soft_rst;
  assign data_cnt  = CNT_W'(cmd_word[12:0]) + CNT_W'(1);

  always_comb begin
    ph_d = ph_q;  wr_d = wr_q;  dat_d = dat_q;  dev_d = dev_q;  blk_d = blk_q;
    term_d = term_q;  ill_d = ill_q;  rdv_d = 1'b0;  rdd_d = rdd_q;
    cs_d = cs_q;  da_d = da_q;  dout_d = dout_q;  rem_d = rem_q;  t_load = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (fire) begin
        unique case (op)
          OP_RREG, OP_WREG: begin
            ph_d = PH_SETUP;  t_load = 1'b1;  dat_d = 1'b0;
            wr_d = (op == OP_WREG);
            cs_d = cmd_word[12:11];  da_d = cmd_word[10:8];
            dout_d = DW'(cmd_word[7:0]);  rem_d = CNT_W'(1);
          end
          OP_DATA: begin
            ph_d = PH_SETUP;  t_load = 1'b1;  dat_d = 1'b1;
            wr_d = cmd_word[15];  cs_d = 2'b10;  da_d = 3'b000;
            rem_d = blk_q ? (data_cnt << WORDS_PER_BLK_LOG2) : data_cnt;
          end
          OP_SETDEV: begin
            dev_d = cmd_word[0];  blk_d = cmd_word[1];
          end
          default: ill_d = 1'b1;
        endcase
      end
      PH_SETUP: if (t_done && data_ok) begin
        ph_d = PH_STROBE;  t_load = 1'b1;
        if (wr_q && dat_q) dout_d = wr_data;
      end
      PH_STROBE: if (t_done && iordy_ok) begin
        ph_d = PH_HOLD;  t_load = 1'b1;
        if (!wr_q) begin
          rdv_d = 1'b1;
          rdd_d = dat_q ? ata_din : DW'(ata_din[7:0]);
        end
      end
      PH_HOLD: if (t_done) begin
        ph_d = PH_RECOV;  t_load = 1'b1;
      end
      PH_RECOV: if (t_done) begin
        rem_d = rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) ph_d = PH_IDLE;
        else begin ph_d = PH_SETUP;  t_load = 1'b1; end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (abort && (ph_q != PH_IDLE)) begin
      ph_d = PH_IDLE;  term_d = 1'b1;  rem_d = '0;  rdv_d = 1'b0;
    end
    if (soft_rst) begin
      ph_d = PH_IDLE;  rem_d = '0;  rdv_d = 1'b0;  term_d = 1'b0;
      ill_d = 1'b0;  dev_d = 1'b0;  blk_d = 1'b0;
    end
  end

  always_comb begin
    unique case (ph_d)
      PH_SETUP:  t_len = tim.t1;
      PH_STROBE: t_len = tim.t2;
      PH_HOLD:   t_len = tim.t4;
      PH_RECOV:  t_len = tim.teoc;
      default:   t_len = '0;
    endcase
  end

  ata_pio_timer #(.W(TFW)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .load(t_load), .len(t_len), .done(t_done)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ph_q <= PH_IDLE;  wr_q <= 1'b0;  dat_q <= 1'b0;  dev_q <= 1'b0;
      blk_q <= 1'b0;  term_q <= 1'b0;  ill_q <= 1'b0;  rdv_q <= 1'b0;
      rdd_q <= '0;  cs_q <= '0;  da_q <= '0;  dout_q <= '0;  rem_q <= '0;
    end else begin
      ph_q <= ph_d;  wr_q <= wr_d;  dat_q <= dat_d;  dev_q <= dev_d;
      blk_q <= blk_d;  term_q <= term_d;  ill_q <= ill_d;  rdv_q <= rdv_d;
      rdd_q <= rdd_d;  cs_q <= cs_d;  da_q <= da_d;  dout_q <= dout_d;
      rem_q <= rem_d;
    end
  end

  assign ata_cs      = (ph_q == PH_IDLE) ? 2'b00 : cs_q;
  assign ata_da      = (ph_q == PH_IDLE) ? 3'b000 : da_q;
  assign ata_rd_n    = !((ph_q == PH_STROBE) && !wr_q);
  assign ata_wr_n    = !((ph_q == PH_STROBE) && wr_q);
  assign ata_doe     = wr_q && ((ph_q == PH_STROBE) || (ph_q == PH_HOLD));
  assign ata_dout    = dout_q;
  assign rd_valid    = rdv_q;
  assign rd_data     = rdd_q;
  assign busy        = (ph_q != PH_IDLE);
  assign rem_cnt     = rem_q;
  assign term_err    = term_q;
  assign illegal_err = ill_q;
  assign dev_sel     = dev_q;
  assign blk_unit    = blk_q;
endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [15:0]      cmd_word,
  input logic             cmd_ready,
  input logic             wr_ready,
  input logic             abort,
  input logic             soft_rst,
  input logic             ata_rd_n,
  input logic             ata_wr_n,
  input logic             busy,
  input logic [CNT_W-1:0] rem_cnt,
  input logic             term_err,
  input logic             illegal_err
);
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));

  assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n || !ata_wr_n) |-> busy);

  assert_rem_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (rem_cnt <= $past(rem_cnt)));

  assert_pop_then_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> !ata_wr_n);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy && !soft_rst) |=> (!busy && term_err));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !term_err && !illegal_err));

  assert_illegal_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_err && !soft_rst) |=> illegal_err);

  assert_setdev_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !busy && !soft_rst && cmd_word[15:2] == 14'h2740)
      |=> !busy);
endmodule

bind ata_pio_seq ata_pio_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .cmd_ready(cmd_ready), .wr_ready(wr_ready), .abort(abort), .soft_rst(soft_rst),
  .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .busy(busy), .rem_cnt(rem_cnt),
  .term_err(term_err), .illegal_err(illegal_err)
);

// File: tb/ata_pio_seq_bench.sv
`timescale 1ns/1ps
module ata_pio_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_valid, abort, soft_rst, rd_ready, ata_iordy, wgate;
  logic [15:0] cmd_word;
  logic [31:0] reg_tim0, dat_tim0, reg_tim1, dat_tim1;
  logic [1:0]  iordy_en;
  logic cmd_ready, wr_ready, rd_valid, ata_rd_n, ata_wr_n, ata_doe, busy;
  logic term_err, illegal_err, dev_sel, blk_unit, wr_valid;
  logic [15:0] wr_data, rd_data, ata_dout, ata_din, rem_cnt;
  logic [1:0] ata_cs;
  logic [2:0] ata_da;

  int widx = 0;
  logic [7:0] rdcnt = 8'd0;
  assign wr_valid = wgate;
  assign wr_data  = 16'h5A00 ^ 16'(widx);
  assign ata_din  = {3'b000, ata_cs, ata_da, rdcnt};

  always @(posedge clk) if (wr_ready && wr_valid) widx <= widx + 1;

  ata_pio_seq u_ata_pio_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .reg_tim0(reg_tim0), .dat_tim0(dat_tim0),
    .reg_tim1(reg_tim1), .dat_tim1(dat_tim1), .iordy_en(iordy_en),
    .abort(abort), .soft_rst(soft_rst), .ata_cs(ata_cs), .ata_da(ata_da),
    .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dout(ata_dout),
    .ata_doe(ata_doe), .ata_din(ata_din), .ata_iordy(ata_iordy),
    .busy(busy), .rem_cnt(rem_cnt), .term_err(term_err),
    .illegal_err(illegal_err), .dev_sel(dev_sel), .blk_unit(blk_unit)
  );

  int checks = 0, fails = 0, cyc = 0;
  int wlen = 0, rlen = 0, wev = 0, rev = 0, last_wlen = 0, last_rlen = 0, rn = 0;
  logic [15:0] wcap;
  logic [1:0]  wcs, rcs;
  logic [2:0]  wda, rda;
  logic [15:0] rq [64];

  always @(negedge clk) begin
    if (!ata_wr_n) begin
      wlen++; wcs = ata_cs; wda = ata_da;
      wcap = ata_doe ? ata_dout : 16'hxxxx;
    end else if (wlen != 0) begin last_wlen = wlen; wev++; wlen = 0; end
    if (!ata_rd_n) begin rlen++; rcs = ata_cs; rda = ata_da; end
    else if (rlen != 0) begin last_rlen = rlen; rev++; rlen = 0; rdcnt++; end
    if (rd_valid && rd_ready) begin rq[rn % 64] = rd_data; rn++; end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; $display("FAIL watchdog act=%0d exp=<150000", cyc);
      report(); $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
  endtask

  function automatic int mx(input int v); return (v == 0) ? 1 : v; endfunction
  function automatic int psum(input logic [31:0] t);
    return mx(t[7:0]) + mx(t[15:8]) + mx(t[23:16]) + mx(t[31:24]);
  endfunction

  task automatic send(input logic [15:0] w);
    cmd_word = w; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run(input logic [15:0] w, output int n);
    send(w); n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n, w0, r0, exp_n;
    logic [7:0] b;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; abort = 1'b0; soft_rst = 1'b0;
    rd_ready = 1'b1; ata_iordy = 1'b1; wgate = 1'b1; iordy_en = 2'b00;
    reg_tim0 = 32'h0101_0101; dat_tim0 = 32'h0201_0102;
    reg_tim1 = 32'h0302_0403; dat_tim1 = 32'h0101_0101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(!busy && rem_cnt == 0 && ata_rd_n && ata_wr_n && cmd_ready, "R12 idle", {busy, rem_cnt}, 0);
    chk(!term_err && !illegal_err && !dev_sel && !blk_unit, "R12 flags",
        {term_err, illegal_err, dev_sel, blk_unit}, 0);

    // R2 R5 sweep of register timing and addresses
    for (int i = 0; i < 81; i++) begin
      reg_tim0 = {8'(i / 27), 8'((i / 9) % 3), 8'((i / 3) % 3), 8'(i % 3)};
      b = 8'(i * 7 + 3); w0 = wev;
      run({3'b101, 2'(i), 3'(i), b}, n);
      chk(n == psum(reg_tim0), "R5 cycle length", n, psum(reg_tim0));
      chk(last_wlen == mx(reg_tim0[15:8]) && wev == w0 + 1, "R5 strobe width",
          last_wlen, mx(reg_tim0[15:8]));
      chk(wcap == {8'h00, b} && wcs == 2'(i) && wda == 3'(i), "R2 write fields",
          {wcap, wcs, wda}, {8'h00, b, 2'(i), 3'(i)});
    end
    reg_tim0 = 32'h0101_0201;

    // R1 register reads over all addresses, low byte of word ignored
    for (int i = 0; i < 32; i++) begin
      r0 = rn; b = rdcnt;
      run({3'b001, 5'(i), 8'(8'hFF - i)}, n);
      chk(rn == r0 + 1 && rq[r0 % 64] == {8'h00, b}, "R1 read data",
          rq[r0 % 64], {8'h00, b});
      chk(rcs == 2'(i >> 3) && rda == 3'(i), "R1 read addr", {rcs, rda}, 5'(i));
    end

    // R3 R8 data read, byte unit, N=2
    r0 = rn; b = rdcnt;
    send(16'h4002);
    chk(rem_cnt == 3 && busy, "R8 remaining at start", rem_cnt, 3);
    while (busy) @(negedge clk);
    chk(rn == r0 + 3, "R3 read count", rn - r0, 3);
    for (int k = 0; k < 3; k++)
      chk(rq[(r0 + k) % 64] == {3'b000, 2'b10, 3'b000, 8'(b + k)}, "R3 read word",
          rq[(r0 + k) % 64], {3'b000, 2'b10, 3'b000, 8'(b + k)});

    // R4 block unit, then R3 data write of 4 words
    run(16'h9D02, n);
    chk(n == 0 && blk_unit && !dev_sel, "R4 set block unit", {n[3:0], blk_unit, dev_sel}, 2);
    w0 = widx;
    run(16'hC000, n);
    exp_n = 4 * psum(dat_tim0);
    chk(n == exp_n, "R3 block write length", n, exp_n);
    chk(widx == w0 + 4 && wcap == (16'h5A00 ^ 16'(w0 + 3)) && wcs == 2'b10 && wda == 0,
        "R3 block write data", wcap, 16'h5A00 ^ 16'(w0 + 3));

    // R4 R6 slave select: register timing of device 1, IORDY ignored
    run(16'h9D01, n);
    chk(dev_sel && !blk_unit, "R4 slave select", {dev_sel, blk_unit}, 2);
    ata_iordy = 1'b0;
    run(16'hA155, n);
    chk(n == psum(reg_tim1) && last_wlen == 4, "R6 ignored when disabled", last_wlen, 4);
    ata_iordy = 1'b1;

    // R6 stretch on device 0
    run(16'h9D00, n);
    iordy_en = 2'b01; ata_iordy = 1'b0;
    send(16'hA0AA);
    while (ata_wr_n) @(negedge clk);
    repeat (5) @(negedge clk);
    ata_iordy = 1'b1;
    while (busy) @(negedge clk);
    chk(last_wlen == 6, "R6 strobe stretched", last_wlen, 6);
    iordy_en = 2'b00;

    // R7 write stall
    wgate = 1'b0; w0 = wev;
    send(16'hC000);
    repeat (8) @(negedge clk);
    chk(busy && wev == w0 && wlen == 0, "R7 write stalls", wev - w0, 0);
    wgate = 1'b1;
    while (busy) @(negedge clk);
    chk(wev == w0 + 1, "R7 write resumes", wev - w0, 1);

    // R7 read stall
    rd_ready = 1'b0; r0 = rev;
    send(16'h4000);
    repeat (8) @(negedge clk);
    chk(busy && rev == r0 && rlen == 0, "R7 read stalls", rev - r0, 0);
    rd_ready = 1'b1;
    while (busy) @(negedge clk);
    chk(rev == r0 + 1, "R7 read resumes", rev - r0, 1);

    // R9 abort in the same cycle as the pending pop
    wgate = 1'b0; w0 = widx; r0 = wev;
    send(16'hC003);
    repeat (5) @(negedge clk);
    wgate = 1'b1; abort = 1'b1;
    @(negedge clk);
    abort = 1'b0; wgate = 1'b0;
    chk(!busy && term_err && rem_cnt == 0, "R9 abort to idle", {busy, term_err}, 1);
    chk(widx == w0 && wev == r0 && wlen == 0, "R9 pop suppressed", widx - w0, 0);
    wgate = 1'b1;

    // R11 illegal words
    run(16'h0000, n);
    chk(n == 0 && illegal_err, "R11 opcode 000", illegal_err, 1);
    w0 = wev; r0 = rev;
    run(16'h9D04, n);
    chk(n == 0 && illegal_err && wev == w0 && rev == r0, "R11 bad set word", n, 0);

    // R10 soft reset together with a valid command
    run(16'h9D03, n);
    soft_rst = 1'b1; cmd_word = 16'hC005; cmd_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!busy && cmd_ready, "R10 discard while held", busy, 0);
    end
    soft_rst = 1'b0; cmd_valid = 1'b0;
    @(negedge clk);
    chk(!busy && !term_err && !illegal_err && !dev_sel && !blk_unit, "R10 cleared",
        {busy, term_err, illegal_err, dev_sel, blk_unit}, 0);

    // R9 abort while idle has no effect
    abort = 1'b1; @(negedge clk); abort = 1'b0; @(negedge clk);
    chk(!term_err && !busy, "R9 idle abort ignored", term_err, 0);

    report();
    $finish;
  end
endmodule